// File: doc/BRIEF.md
# Shared 64-bit System Timer with Per-Core Compare Events

This block keeps one free-running 64-bit up-counter that every processor core in a cluster sees, and gives each core a private comparator. A core programs a 64-bit deadline. When the shared count is equal to or beyond that deadline and the core's comparator is armed, the core's event flag goes high. If the core has interrupts enabled, its interrupt line is raised as well. With auto-increment enabled, each event adds a core-specific step to the deadline, so one setup yields a steady stream of periodic events.

All access goes through one 32-bit register port. The 64-bit quantities appear as pairs of 32-bit words. A core-index input chooses whose private copy of the control bits, comparator, step and flag a bus access touches. The counter keeps running while it is being read, so software reads the upper half, then the lower half, then the upper half again, and retries if the two upper reads differ. To load a start value, software stops the counter, writes both halves and then restarts it.

Top module: `gtimer`

## Requirements
- R1: After reset the counter reads 0 and is stopped, every control field and event flag reads 0, and all interrupt outputs are low.
- R2: While the shared run bit (bit 0 of the control word at offset 0x08) is set and no counter word is being written, the counter rises by exactly one per clock.
- R3: While the run bit is clear, the counter holds its value.
- R4: A write to offset 0x00 replaces bits 31:0 of the counter and a write to offset 0x04 replaces bits 63:32. The other half is left unchanged and the new value reads back.
- R5: When a core's compare-enable bit (control bit 1) is set and the counter is greater than or equal to that core's 64-bit compare value (low word at 0x10, high word at 0x14), the core's event flag (bit 0 at offset 0x0C) reads 1 from the next cycle on.
- R6: While a core's compare-enable bit is clear, no counter or comparator value sets its event flag.
- R7: Writing 1 to bit 0 at offset 0x0C clears the selected core's event flag. If a match is present in the same cycle, the flag stays set.
- R8: When a core's auto-increment bit (control bit 3) is set and a match occurs, the core's compare value grows by its 32-bit step (offset 0x18), zero-extended, once per matching cycle. A comparator write in the same cycle takes priority over the increment.
- R9: A core's interrupt output is high exactly when its event flag is set and its interrupt-enable bit (control bit 2) is set.
- R10: Control bits 3:1, the comparator, the step and the event flag are kept separately for each core and are reached through the core index. Bit 0 of the control word is a single shared bit that any core may write.
- R11: The counter wraps from all ones to zero and keeps counting.
- R12: A read returns the value the register held at the request edge, on the cycle after the request, with a valid strobe. Reads never stall the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_core | input | IW | Index of the core whose private registers are accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read request |
| irq | output | NCORES | One interrupt line per core |

## Verification
The comparator is tried with a counter equal to the deadline, one strictly beyond it, and one below it. These three cases tell a greater-or-equal compare apart from an equality compare or an off-by-one compare. The count is tried across a wrap of the full 64 bits and through back-to-back reads while it runs, which separates true 64-bit carry from a 32-bit counter. A flag clear is issued both while a match persists and after the comparator has been disarmed, which exposes a clear that wins over a live match. An auto-increment event is followed by a second look at the deadline, which shows whether the step is added once per match or repeatedly.

// File: rtl/gtimer.sv
module gtimer #(
  parameter int NCORES = 2,
  localparam int IW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [IW-1:0]     bus_core,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [NCORES-1:0] irq
);

  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_STS = 5'h0C,
                         A_MLO = 5'h10, A_MHI = 5'h14, A_INC = 5'h18;

  logic [63:0] ctr;
  logic        run;
  logic [63:0] cmp  [NCORES];
  logic [31:0] ainc [NCORES];
  logic        cen  [NCORES];
  logic        ien  [NCORES];
  logic        aen  [NCORES];
  logic        flag [NCORES];

  wire wr = bus_sel & bus_wr;
  wire rd = bus_sel & ~bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr <= '0;
      run <= 1'b0;
    end else begin
      if (wr && bus_addr == A_CTL) run <= bus_wdata[0];
      if (wr && bus_addr == A_CLO)      ctr[31:0]  <= bus_wdata;
      else if (wr && bus_addr == A_CHI) ctr[63:32] <= bus_wdata;
      else if (run)                     ctr <= ctr + 64'd1;
    end
  end

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    wire mine = (bus_core == IW'(i));
    wire hit  = cen[i] && (ctr >= cmp[i]);
    wire wsel = wr && mine;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp[i]  <= '0;
        ainc[i] <= '0;
        cen[i]  <= 1'b0;
        ien[i]  <= 1'b0;
        aen[i]  <= 1'b0;
        flag[i] <= 1'b0;
      end else begin
        if (wsel && bus_addr == A_CTL) {aen[i], ien[i], cen[i]} <= bus_wdata[3:1];
        if (wsel && bus_addr == A_INC) ainc[i] <= bus_wdata;
        if (wsel && bus_addr == A_MLO)      cmp[i][31:0]  <= bus_wdata;
        else if (wsel && bus_addr == A_MHI) cmp[i][63:32] <= bus_wdata;
        else if (hit && aen[i])             cmp[i] <= cmp[i] + {32'd0, ainc[i]};
        flag[i] <= hit | (flag[i] & ~(wsel && bus_addr == A_STS && bus_wdata[0]));
      end
    end

    assign irq[i] = flag[i] & ien[i];
  end

  logic [IW-1:0] cix;
  assign cix = (int'(bus_core) < NCORES) ? bus_core : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) begin
        case (bus_addr)
          A_CLO:   bus_rdata <= ctr[31:0];
          A_CHI:   bus_rdata <= ctr[63:32];
          A_CTL:   bus_rdata <= {28'd0, aen[cix], ien[cix], cen[cix], run};
          A_STS:   bus_rdata <= {31'd0, flag[cix]};
          A_MLO:   bus_rdata <= cmp[cix][31:0];
          A_MHI:   bus_rdata <= cmp[cix][63:32];
          A_INC:   bus_rdata <= ainc[cix];
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/gtimer_chk.sv
module gtimer_chk #(
  parameter int NCORES = 2,
  parameter int IW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [4:0]    bus_addr,
  input logic [IW-1:0] bus_core,
  input logic [31:0]   bus_wdata,
  input logic [63:0]   ctr,
  input logic          run,
  input logic [63:0]   cmp  [NCORES],
  input logic [31:0]   ainc [NCORES],
  input logic          cen  [NCORES],
  input logic          aen  [NCORES],
  input logic          flag [NCORES]
);

  wire ctr_wr = bus_sel && bus_wr && (bus_addr == 5'h00 || bus_addr == 5'h04);

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !ctr_wr |=> ctr == $past(ctr) + 64'd1);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ctr_wr |=> $stable(ctr));

  p_lowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == 5'h00 |=> ctr[31:0] == $past(bus_wdata) && $stable(ctr[63:32]));

  for (genvar i = 0; i < NCORES; i++) begin : g_chk
    wire cmp_wr = bus_sel && bus_wr && bus_core == IW'(i) &&
                  (bus_addr == 5'h10 || bus_addr == 5'h14);

    p_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cen[i] && ctr >= cmp[i] |=> flag[i]);

    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cen[i] && !flag[i] |=> !flag[i]);

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cen[i] && aen[i] && ctr >= cmp[i] && !cmp_wr |=> cmp[i] == $past(cmp[i]) + {32'd0, $past(ainc[i])});
  end

endmodule

bind gtimer gtimer_chk #(.NCORES(NCORES), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_core(bus_core), .bus_wdata(bus_wdata), .ctr(ctr), .run(run), .cmp(cmp),
  .ainc(ainc), .cen(cen), .aen(aen), .flag(flag)
);

// File: tb/tb_gtimer.sv
`timescale 1ns/1ps
module tb_gtimer;
  localparam int NC = 2;
  localparam int IW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [IW-1:0] bus_core = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NC-1:0] irq;

  gtimer #(.NCORES(NC)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  logic [63:0] mctr;
  logic men;
  always @(posedge clk) begin
    if (!rst_n) begin
      mctr <= '0; men <= 1'b0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == 5'h08) men <= bus_wdata[0];
      if (bus_sel && bus_wr && bus_addr == 5'h00)      mctr[31:0]  <= bus_wdata;
      else if (bus_sel && bus_wr && bus_addr == 5'h04) mctr[63:32] <= bus_wdata;
      else if (men) mctr <= mctr + 64'd1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input int c, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_core = IW'(c); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input int c, input logic [31:0] e, input bit mdl, input string t);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_core = IW'(c);
    @(posedge clk);
    if (mdl) e = (a == 5'h00) ? mctr[31:0] : mctr[63:32];
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic chk_irq(input logic [NC-1:0] e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk_irq('0, "R1 irq low after reset");
    rd(5'h08, 0, 0, 0, "R1 control zero");
    rd(5'h00, 0, 0, 0, "R1 counter zero");
    rd(5'h0C, 1, 0, 0, "R1 flag zero");

    wr(5'h08, 0, 1); idle(5);
    rd(5'h00, 0, 0, 1, "R12 low read while running");
    rd(5'h00, 0, 0, 1, "R2 next low read advances");
    rd(5'h04, 0, 0, 1, "R2 high word");

    wr(5'h08, 0, 0);
    rd(5'h00, 0, 0, 1, "R3 stopped");
    idle(4);
    rd(5'h00, 0, 0, 1, "R3 holds");

    wr(5'h00, 0, 32'hFFFF_FFFD); wr(5'h04, 0, 32'hFFFF_FFFF);
    rd(5'h04, 0, 32'hFFFF_FFFF, 0, "R4 high write");
    rd(5'h00, 0, 32'hFFFF_FFFD, 0, "R4 low write");
    wr(5'h08, 0, 1); idle(3); wr(5'h08, 0, 0);
    rd(5'h04, 0, 0, 0, "R11 wrapped high");
    rd(5'h00, 0, 1, 0, "R11 wrapped low");

    wr(5'h00, 0, 100); wr(5'h04, 0, 0);
    rd(5'h00, 0, 100, 0, "R4 reload");
    wr(5'h10, 0, 100); wr(5'h14, 0, 0); idle(2);
    rd(5'h0C, 0, 0, 0, "R6 disarmed no event");
    chk_irq('0, "R6 irq low");

    wr(5'h08, 0, 6); idle(1);
    chk_irq(2'b01, "R9 core0 irq");
    rd(5'h0C, 0, 1, 0, "R5 equal match");

    wr(5'h10, 1, 50); wr(5'h14, 1, 0); wr(5'h08, 1, 2); idle(1);
    rd(5'h0C, 1, 1, 0, "R5 greater match");
    chk_irq(2'b01, "R9 core1 irq disabled");
    rd(5'h08, 1, 2, 0, "R10 core1 bits");
    rd(5'h08, 0, 6, 0, "R10 core0 bits");

    wr(5'h0C, 0, 1); idle(1);
    rd(5'h0C, 0, 1, 0, "R7 live match wins");
    wr(5'h08, 0, 4); wr(5'h0C, 0, 1); idle(1);
    rd(5'h0C, 0, 0, 0, "R7 cleared");
    chk_irq('0, "R9 cleared");
    wr(5'h08, 1, 0); wr(5'h0C, 1, 1);

    wr(5'h10, 0, 200); wr(5'h14, 0, 0); wr(5'h18, 0, 10); wr(5'h08, 0, 32'hA); idle(1);
    rd(5'h0C, 0, 0, 0, "R8 below deadline");
    wr(5'h00, 0, 200); idle(1);
    rd(5'h10, 0, 210, 0, "R8 stepped");
    rd(5'h0C, 0, 1, 0, "R8 event");
    idle(2);
    rd(5'h10, 0, 210, 0, "R8 single step");
    wr(5'h0C, 0, 1); idle(1);
    rd(5'h0C, 0, 0, 0, "R8 clear after step");

    wr(5'h08, 1, 1); idle(3);
    rd(5'h00, 0, 0, 1, "R10 shared run bit");
    rd(5'h08, 0, 32'hB, 0, "R10 core0 bits kept");
    wr(5'h08, 0, 0); idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule